// File: doc/BRIEF.md
# Daisy-Chain Node Initialization Sequencer

This block is the control state machine for one node on a daisy-chained sensor bus. When an already-decoded initialization command arrives, it takes the node address from the command. It can then run a single timed fault check on whichever side of the node's pass-through switch is not yet live. Finally it decides whether the switch closes so that traffic reaches the next node in the chain.

The command's direction picks the side under test:
- A forward initialization checks the downstream port.
- A reverse initialization checks the upstream port.

During the check a pull-down is enabled on that side and an overvoltage comparator is watched for a fixed number of cycles. The switch closes only if the comparator never reports a high level in that window. A command whose switch bit is clear runs no check and leaves the switch open. In a loop-back arrangement both sides are already driven, so the check is skipped and the switch closes at once. Address zero is a global address: the node takes address zero, the switch stays open, and the store and switch bits are ignored.

Top module: `node_init_seq`

## Requirements
- R1: The cycle after a command is accepted (`cmd_valid` high at a rising edge), `node_addr` equals that command's `cmd_addr`.
- R2: A command with a nonzero address, `cmd_switch`=1, `loop_back`=0 and `cmd_rev`=0 (forward) raises `pd_dn_en` for exactly TEST_CYCLES consecutive cycles, starting the cycle after the command. `pd_up_en` stays low throughout.
- R3: The same command with `cmd_rev`=1 (reverse) raises `pd_up_en` for exactly TEST_CYCLES cycles, and `pd_dn_en` stays low.
- R4: If `side_hi` is never high in a cycle where a pull-down is high, `sw_close` rises in the same cycle the pull-down drops. `sw_close` and a pull-down are never high together.
- R5: If `side_hi` is high in any cycle where a pull-down is high, `fault` is high from the next cycle on and `sw_close` stays low. `fault` holds until the cycle after the next accepted command, which clears it.
- R6: A command with a nonzero address and `cmd_switch`=0 runs no check, and `sw_close` is low the cycle after it.
- R7: A command with a nonzero address, `cmd_switch`=1 and `loop_back`=1 raises no pull-down and sets no fault. `sw_close` is high the cycle after it.
- R8: A command with `cmd_addr`=0 gives `node_addr`=0, `sw_close`=0, no pull-down and no `cfg_store` pulse, whatever `cmd_keep` and `cmd_switch` are.
- R9: `cfg_store` is a one-cycle pulse the cycle after a command with `cmd_keep`=1 and a nonzero address. At all other times it is low.
- R10: A command accepted while a check is running aborts that check. The next cycle, the outputs follow the new command only, including the side and length of any new window.
- R11: `side_hi` outside a check window never sets `fault`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle strobe of a decoded initialization command |
| cmd_rev | input | 1 | Direction: 0 forward (downstream side inactive), 1 reverse (upstream side inactive) |
| cmd_addr | input | ADDR_W | Address carried by the command; 0 is the global address |
| cmd_keep | input | 1 | Request to store the configuration persistently |
| cmd_switch | input | 1 | Request to test and close the pass-through switch |
| side_hi | input | 1 | Comparator: inactive side above the fault threshold |
| loop_back | input | 1 | Both switch sides are driven (ring topology) |
| node_addr | output | ADDR_W | Current node address |
| sw_close | output | 1 | Pass-through switch close enable |
| pd_dn_en | output | 1 | Pull-down enable on the downstream side |
| pd_up_en | output | 1 | Pull-down enable on the upstream side |
| fault | output | 1 | Fault seen during the last check |
| cfg_store | output | 1 | One-cycle strobe to store the configuration |

## Verification
Two pairs of events can fall in the same cycle, and the bench provokes both.

The first pair is the end of the check window and the last comparator sample. The bench raises `side_hi` only in the final pull-down cycle. It then expects the switch to stay open and `fault` to rise in the cycle where the pull-down drops.

The second pair is the end of the window and a new command. The bench issues a command with the switch bit clear exactly in the last window cycle. It expects the abort to win: no switch closure, the new address, and a cleared fault.

// File: rtl/nis_pkg.sv
package nis_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_TEST = 1'b1} nis_state_t;

  // A timed check is wanted only for a non-global, switch-requesting, non-ring command
  function automatic logic needs_test(input logic global_addr, input logic sw_req,
                                      input logic ring);
    return !global_addr && sw_req && !ring;
  endfunction

  // Ring topology: switch closes immediately without a check
  function automatic logic direct_close(input logic global_addr, input logic sw_req,
                                        input logic ring);
    return !global_addr && sw_req && ring;
  endfunction

  // Verdict at window end, including the last sample taken in that cycle
  function automatic logic close_ok(input logic seen, input logic last_sample);
    return !(seen || last_sample);
  endfunction
endpackage

// File: rtl/nis_window_timer.sv
module nis_window_timer #(
  parameter int TEST_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic win_end
);
  localparam int CNT_W = (TEST_CYCLES > 1) ? $clog2(TEST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TEST_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (start)  cnt <= '0;
    else if (run)    cnt <= cnt + 1'b1;
  end

  assign win_end = run && (cnt == LAST);
endmodule

// File: rtl/nis_pd_steer.sv
module nis_pd_steer (
  input  logic testing,
  input  logic rev,
  output logic pd_dn_en,
  output logic pd_up_en
);
  assign pd_dn_en = testing && !rev;
  assign pd_up_en = testing &&  rev;
endmodule

// File: rtl/node_init_seq.sv
module node_init_seq #(
  parameter int ADDR_W      = 4,
  parameter int TEST_CYCLES = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_rev,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_keep,
  input  logic              cmd_switch,
  input  logic              side_hi,
  input  logic              loop_back,
  output logic [ADDR_W-1:0] node_addr,
  output logic              sw_close,
  output logic              pd_dn_en,
  output logic              pd_up_en,
  output logic              fault,
  output logic              cfg_store
);
  import nis_pkg::*;

  nis_state_t state;
  logic       rev_q;
  logic       global_addr;
  logic       test_start;
  logic       testing;
  logic       win_end;
  logic       fault_sample;

  assign global_addr  = (cmd_addr == '0);
  assign test_start   = cmd_valid && needs_test(global_addr, cmd_switch, loop_back);
  assign testing      = (state == ST_TEST);
  assign fault_sample = testing && side_hi;

  nis_window_timer #(.TEST_CYCLES(TEST_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (cmd_valid),
    .run     (testing),
    .win_end (win_end)
  );

  nis_pd_steer u_steer (
    .testing  (testing),
    .rev      (rev_q),
    .pd_dn_en (pd_dn_en),
    .pd_up_en (pd_up_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rev_q     <= 1'b0;
      node_addr <= '0;
      sw_close  <= 1'b0;
      fault     <= 1'b0;
      cfg_store <= 1'b0;
    end else if (cmd_valid) begin
      node_addr <= cmd_addr;
      rev_q     <= cmd_rev;
      fault     <= 1'b0;
      cfg_store <= cmd_keep && !global_addr;
      sw_close  <= direct_close(global_addr, cmd_switch, loop_back);
      state     <= test_start ? ST_TEST : ST_IDLE;
    end else begin
      cfg_store <= 1'b0;
      if (fault_sample) fault <= 1'b1;
      if (win_end) begin
        state    <= ST_IDLE;
        sw_close <= close_ok(fault, side_hi);
      end
    end
  end
endmodule

// File: rtl/nis_checker.sv
module nis_checker #(
  parameter int ADDR_W      = 4,
  parameter int TEST_CYCLES = 50000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_rev,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_keep,
  input logic              cmd_switch,
  input logic              loop_back,
  input logic              win_end,
  input logic [ADDR_W-1:0] node_addr,
  input logic              sw_close,
  input logic              pd_dn_en,
  input logic              pd_up_en,
  input logic              fault,
  input logic              cfg_store
);
  logic pd_any;
  int   pd_run;
  assign pd_any = pd_dn_en || pd_up_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pd_run <= 0;
    else if (cmd_valid || !pd_any) pd_run <= 0;
    else                           pd_run <= pd_run + 1;
  end

  AST_ADDR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> node_addr == $past(cmd_addr)); // R1
  AST_FWD_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_addr != '0 && cmd_switch && !loop_back && !cmd_rev) |=> pd_dn_en && !pd_up_en); // R2
  AST_REV_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_addr != '0 && cmd_switch && !loop_back && cmd_rev) |=> pd_up_en && !pd_dn_en); // R3
  AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    pd_any |-> pd_run < TEST_CYCLES); // R2
  AST_NO_CLOSE_DURING_PD: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_close && pd_any)); // R4
  AST_END_WITH_PD: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |-> pd_any); // R4
  AST_FAULT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !sw_close); // R5
  AST_NO_TEST_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_addr != '0 && !cmd_switch) |=> !sw_close && !pd_any); // R6
  AST_RING_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_addr != '0 && cmd_switch && loop_back) |=> sw_close && !pd_any && !fault); // R7
  AST_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_addr == '0) |=> node_addr == '0 && !sw_close && !pd_any && !cfg_store); // R8
  AST_STORE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_store |=> !cfg_store); // R9
  AST_STORE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_keep && cmd_addr != '0) |=> cfg_store); // R9
  AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !fault); // R5
  AST_FAULT_ONLY_IN_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(pd_any)); // R11
endmodule

bind node_init_seq nis_checker #(.ADDR_W(ADDR_W), .TEST_CYCLES(TEST_CYCLES)) u_nis_checker (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rev(cmd_rev), .cmd_addr(cmd_addr),
  .cmd_keep(cmd_keep), .cmd_switch(cmd_switch), .loop_back(loop_back), .win_end(win_end),
  .node_addr(node_addr), .sw_close(sw_close), .pd_dn_en(pd_dn_en), .pd_up_en(pd_up_en),
  .fault(fault), .cfg_store(cfg_store)
);

// File: tb/tb_node_init_seq.sv
module tb_node_init_seq;
  localparam int AW = 3;
  localparam int T  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_rev = 1'b0, cmd_keep = 1'b0, cmd_switch = 1'b0;
  logic side_hi = 1'b0, loop_back = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [AW-1:0] node_addr;
  logic sw_close, pd_dn_en, pd_up_en, fault, cfg_store;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  node_init_seq #(.ADDR_W(AW), .TEST_CYCLES(T)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rev(cmd_rev), .cmd_addr(cmd_addr),
    .cmd_keep(cmd_keep), .cmd_switch(cmd_switch), .side_hi(side_hi), .loop_back(loop_back),
    .node_addr(node_addr), .sw_close(sw_close), .pd_dn_en(pd_dn_en), .pd_up_en(pd_up_en),
    .fault(fault), .cfg_store(cfg_store)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drive a command for one cycle; returns one negedge after the accepting edge
  task automatic issue(input bit rev, input int addr, input bit keep, input bit sw, input bit ring);
    cmd_valid = 1'b1; cmd_rev = rev; cmd_addr = AW'(addr);
    cmd_keep = keep; cmd_switch = sw; loop_back = ring;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_keep = 1'b0; cmd_switch = 1'b0; loop_back = 1'b0;
  endtask

  // fm: 0 no fault, 1 fault on first window cycle, 2 fault on last window cycle
  task automatic run_case(input bit rev, input int addr, input bit keep, input bit sw,
                          input bit ring, input int fm);
    bit glob, tst, ring_close;
    glob = (addr == 0);
    tst = !glob && sw && !ring;
    ring_close = !glob && sw && ring;
    issue(rev, addr, keep, sw, ring);
    chk("R1 node_addr", node_addr, glob ? 0 : addr);
    chk("R9/R8 cfg_store", cfg_store, keep && !glob);
    chk("R2 pd_dn_en", pd_dn_en, tst && !rev);
    chk("R3 pd_up_en", pd_up_en, tst && rev);
    chk("R5 fault cleared by cmd", fault, 0);
    if (tst) begin
      for (int i = 0; i < T; i++) begin
        chk(rev ? "R3 window high" : "R2 window high", rev ? pd_up_en : pd_dn_en, 1);
        chk("R4 open during window", sw_close, 0);
        side_hi = (fm == 1 && i == 0) || (fm == 2 && i == T - 1);
        @(negedge clk);
        if (i == 0) chk("R9 store pulse one cycle", cfg_store, 0);
      end
      side_hi = 1'b0;
      chk("R2/R3 window length", pd_dn_en || pd_up_en, 0);
      chk(fm == 0 ? "R4 close at window end" : "R5 fault keeps open", sw_close, fm == 0);
      chk("R5 fault flag", fault, fm != 0);
      repeat (3) @(negedge clk);
      chk("R5 fault held", fault, fm != 0);
      chk("R5 switch held", sw_close, fm == 0);
    end else begin
      chk(glob ? "R8 global open" : (ring ? "R7 ring close" : "R6 no-test open"),
          sw_close, ring_close);
      side_hi = 1'b1;
      @(negedge clk);
      side_hi = 1'b0;
      chk("R11 side_hi ignored outside window", fault, 0);
      chk("R7/R8 no pull-down", pd_dn_en || pd_up_en, 0);
      chk("R9 store pulse one cycle", cfg_store, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset node_addr", node_addr, 0);
    chk("R4 reset sw_close", sw_close, 0);
    chk("R2 reset pull-downs", pd_dn_en || pd_up_en, 0);
    chk("R5 reset fault", fault, 0);
    chk("R9 reset cfg_store", cfg_store, 0);

    for (int fm = 0; fm < 3; fm++)
      for (int combo = 0; combo < 16; combo++)
        for (int a = 0; a < (1 << AW); a++)
          run_case(combo[0], a, combo[1], combo[2], combo[3], fm);

    // R10: forward test aborted by a reverse command mid-window
    issue(1'b0, 3, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    issue(1'b1, 5, 1'b0, 1'b1, 1'b0);
    chk("R10 new side up", pd_up_en, 1);
    chk("R10 old side dropped", pd_dn_en, 0);
    chk("R10 new address", node_addr, 5);
    for (int i = 1; i < T; i++) @(negedge clk);
    chk("R10 full new window", pd_up_en, 1);
    @(negedge clk);
    chk("R10 window restarted length", pd_up_en, 0);
    chk("R10 closes after new window", sw_close, 1);

    // R10: fault on last window cycle together with a new no-switch command
    issue(1'b0, 2, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < T - 1; i++) @(negedge clk);
    side_hi = 1'b1;
    issue(1'b0, 6, 1'b0, 1'b0, 1'b0);
    side_hi = 1'b0;
    chk("R10 abort wins at window end sw", sw_close, 0);
    chk("R10 abort wins at window end fault", fault, 0);
    chk("R10 abort wins address", node_addr, 6);
    chk("R10 abort no pull-down", pd_dn_en || pd_up_en, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule